// File: doc/BRIEF.md
# Two-Level Translation Lookup

This block decides whether a virtual page pair is present in a translation buffer that is built from two parts, and reports where. The first part is set-associative: a number of ways, each holding one entry per set, and all of them use one page size chosen by the `sa_ps_i` input. The second part is a small fully associative array in which every entry stores its own page size. An entry covers an even/odd pair of pages, so the comparison works on the address bits above the pair boundary (page size + 1).

The lookup input is the page-pair part of the virtual address (address bits 47 down to 13) together with the current address-space identifier. The page offset plays no part in the lookup, so it is not taken in. The set-associative part is consulted first. The fully associative part only decides the result when no way of the selected set matches. The hit flag and the entry index come out of a register one clock after the inputs. Entries are loaded through a single write port that takes a flat entry index and the entry fields.

Top module: `tlbsrch_top`

## Requirements
- R1: After a synchronous active-low reset, every entry is absent. No lookup hits until an entry has been written.
- R2: The set-associative set is the low log2(SA_SETS) bits of the pair number shifted right by (`sa_ps_i` − 12). A hit in way w, set s reports index w × SA_SETS + s.
- R3: An entry whose present bit is clear never matches, whatever its other fields hold.
- R4: A present entry matches only if its global bit is set or its stored identifier equals `lk_asid_i`. A global entry matches under any identifier.
- R5: With page size p (p ≥ 12), the stored and looked-up pair numbers are compared after both are shifted right by (p − 12). The lower bits are ignored.
- R6: If a set-associative way matches, its index is reported even when fully associative entries also match.
- R7: Fully associative entry k is compared using its own stored page size, not `sa_ps_i`. Its hit is reported as index SA_WAYS × SA_SETS + k.
- R8: When several ways of one set match, the lowest way is reported. When several fully associative entries match, the lowest k is reported.
- R9: `hit_o` and `idx_o` are registered. They reflect the lookup inputs present at the previous rising edge and do not change before that edge.
- R10: A write with `wr_idx_i` below SA_WAYS × SA_SETS stores into way `wr_idx_i` / SA_SETS, set `wr_idx_i` mod SA_SETS. A higher index stores into fully associative entry `wr_idx_i` − SA_WAYS × SA_SETS, together with `wr_ps_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Write one entry this cycle |
| wr_idx_i | input | IDX_W | Flat entry index to write |
| wr_present_i | input | 1 | Present bit of the written entry |
| wr_global_i | input | 1 | Global bit of the written entry |
| wr_asid_i | input | 10 | Address-space identifier of the written entry |
| wr_pair_i | input | 35 | Stored pair number (virtual address bits 47:13) |
| wr_ps_i | input | 6 | Page size (log2 bytes); kept only by fully associative entries |
| lk_pair_i | input | 35 | Looked-up virtual address bits 47:13 |
| lk_asid_i | input | 10 | Current address-space identifier |
| sa_ps_i | input | 6 | Page size of the set-associative part |
| hit_o | output | 1 | Registered match flag |
| idx_o | output | IDX_W | Registered index of the matched entry (0 on a miss) |

## Verification
Every set of a small configuration is filled with a distinct tag in one way. Each entry is then looked up under the 4 KiB page size, which separates the way and set arithmetic of the index from a plain tag compare. Mismatched identifiers, a global entry and a cleared present bit tell the identifier filter apart from the existence filter. Lookups under larger page sizes vary the bits below the pair boundary and catch a wrong compare shift, and a fully associative entry whose page size differs from `sa_ps_i` shows which size each part uses. Overlapping entries in both parts and several ways fix the search order. A miss-then-hit pair of lookups, sampled just after the drive and again a cycle later, pins the register delay.

// File: rtl/tlbsrch_pkg.sv
// Shared constants, entry type and compare helpers for the two-level lookup.
// Assumes page sizes are at least MIN_PS, so the compare shift never goes negative.
package tlbsrch_pkg;
    localparam int VA_W     = 48;
    localparam int PAIR_LSB = 13;
    localparam int PAIR_W   = VA_W - PAIR_LSB;
    localparam int ASID_W   = 10;
    localparam int PS_W     = 6;
    localparam int MIN_PS   = 12;

    typedef struct packed {
        logic              present;
        logic              glob;
        logic [ASID_W-1:0] asid;
        logic [PAIR_W-1:0] pair;
    } tag_t;

    // Drop the pair-number bits that lie below the pair boundary for page size ps.
    function automatic logic [PAIR_W-1:0] pair_shift(logic [PAIR_W-1:0] v, logic [PS_W-1:0] ps);
        return v >> (ps - PS_W'(MIN_PS));
    endfunction

    // Full match test of one stored entry against a lookup.
    function automatic logic tag_hit(tag_t t, logic [ASID_W-1:0] asid,
                                     logic [PAIR_W-1:0] va_pair, logic [PS_W-1:0] ps);
        return t.present && (t.glob || (t.asid == asid)) &&
               (pair_shift(va_pair, ps) == pair_shift(t.pair, ps));
    endfunction
endpackage

// File: rtl/tlbsrch_set_part.sv
// Set-associative part: WAYS x SETS entries that all share the page size ps_i.
// The set is picked from the pair number above the pair boundary. The lowest matching way wins.
// Assumes WAYS and SETS are powers of two, each at least 2.
module tlbsrch_set_part
    import tlbsrch_pkg::*;
#(
    parameter int WAYS = 8,
    parameter int SETS = 256,
    parameter int WAY_W = $clog2(WAYS),
    parameter int SET_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [WAY_W-1:0]  wr_way_i,
    input  logic [SET_W-1:0]  wr_set_i,
    input  tag_t              wr_tag_i,
    input  logic [PAIR_W-1:0] va_pair_i,
    input  logic [ASID_W-1:0] asid_i,
    input  logic [PS_W-1:0]   ps_i,
    output logic              hit_o,
    output logic [WAY_W-1:0]  way_o,
    output logic [SET_W-1:0]  set_o
);
    tag_t             mem [WAYS][SETS];
    logic [WAYS-1:0]  way_hit;

    // Storage: reset clears every present bit; a write replaces one whole entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++)
                for (int s = 0; s < SETS; s++)
                    mem[w][s].present <= 1'b0;
        end else if (wr_en_i) begin
            mem[wr_way_i][wr_set_i] <= wr_tag_i;
        end
    end

    // Set selection from the pair number above the shared page boundary.
    always_comb set_o = SET_W'(pair_shift(va_pair_i, ps_i));

    // One comparator per way on the selected set.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_hit[w] = tag_hit(mem[w][set_o], asid_i, va_pair_i, ps_i);
    end

    // Priority pick of the lowest matching way.
    always_comb begin
        hit_o = |way_hit;
        way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (way_hit[w]) way_o = WAY_W'(w);
    end

    a_r3_sa_present: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> mem[way_o][set_o].present);
    a_r8_sa_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ((way_hit & ~({WAYS{1'b1}} << way_o)) == '0));
endmodule

// File: rtl/tlbsrch_full_part.sv
// Fully associative part: every entry keeps its own page size and compares with it.
// The lowest matching entry wins. Assumes ENTRIES is at least 2.
module tlbsrch_full_part
    import tlbsrch_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int SLOT_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [SLOT_W-1:0] wr_slot_i,
    input  tag_t              wr_tag_i,
    input  logic [PS_W-1:0]   wr_ps_i,
    input  logic [PAIR_W-1:0] va_pair_i,
    input  logic [ASID_W-1:0] asid_i,
    output logic              hit_o,
    output logic [SLOT_W-1:0] slot_o
);
    tag_t               ent [ENTRIES];
    logic [PS_W-1:0]    eps [ENTRIES];
    logic [ENTRIES-1:0] ent_hit;

    // Storage: reset clears present bits; a write stores tag and page size together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ENTRIES; k++) ent[k].present <= 1'b0;
        end else if (wr_en_i) begin
            ent[wr_slot_i] <= wr_tag;
            eps[wr_slot_i] <= wr_ps_i;
        end
    end

    tag_t wr_tag;
    always_comb wr_tag = wr_tag_i;

    // One comparator per entry, each shifting by its own stored page size.
    for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
        assign ent_hit[k] = tag_hit(ent[k], asid_i, va_pair_i, eps[k]);
    end

    // Priority pick of the lowest matching entry.
    always_comb begin
        hit_o  = |ent_hit;
        slot_o = '0;
        for (int k = ENTRIES - 1; k >= 0; k--)
            if (ent_hit[k]) slot_o = SLOT_W'(k);
    end

    a_r3_fa_present: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ent[slot_o].present);
    a_r8_fa_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ((ent_hit & ~({ENTRIES{1'b1}} << slot_o)) == '0));
endmodule

// File: rtl/tlbsrch_top.sv
// Two-level lookup: the set-associative part first, then the fully associative part.
// The result is registered. Flat index map: way*SETS+set, then SA_TOTAL+k.
// Assumes SA_WAYS*SA_SETS is a power of two and not smaller than FA_ENTRIES.
module tlbsrch_top
    import tlbsrch_pkg::*;
#(
    parameter int SA_WAYS    = 8,
    parameter int SA_SETS    = 256,
    parameter int FA_ENTRIES = 64,
    parameter int IDX_W      = $clog2(SA_WAYS * SA_SETS + FA_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic              wr_present_i,
    input  logic              wr_global_i,
    input  logic [ASID_W-1:0] wr_asid_i,
    input  logic [PAIR_W-1:0] wr_pair_i,
    input  logic [PS_W-1:0]   wr_ps_i,
    input  logic [PAIR_W-1:0] lk_pair_i,
    input  logic [ASID_W-1:0] lk_asid_i,
    input  logic [PS_W-1:0]   sa_ps_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam int SA_TOTAL = SA_WAYS * SA_SETS;
    localparam int WAY_W    = $clog2(SA_WAYS);
    localparam int SET_W    = $clog2(SA_SETS);
    localparam int SLOT_W   = $clog2(FA_ENTRIES);

    tag_t              wr_tag;
    logic              wr_to_sa;
    logic              sa_hit, fa_hit;
    logic [WAY_W-1:0]  sa_way;
    logic [SET_W-1:0]  sa_set;
    logic [SLOT_W-1:0] fa_slot;

    // Write decode: the flat index picks the part, then way/set or entry.
    always_comb begin
        wr_tag   = '{present: wr_present_i, glob: wr_global_i, asid: wr_asid_i, pair: wr_pair_i};
        wr_to_sa = wr_idx_i < IDX_W'(SA_TOTAL);
    end

    tlbsrch_set_part #(.WAYS(SA_WAYS), .SETS(SA_SETS)) u_sa (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i && wr_to_sa),
        .wr_way_i(wr_idx_i[SET_W +: WAY_W]), .wr_set_i(wr_idx_i[SET_W-1:0]),
        .wr_tag_i(wr_tag),
        .va_pair_i(lk_pair_i), .asid_i(lk_asid_i), .ps_i(sa_ps_i),
        .hit_o(sa_hit), .way_o(sa_way), .set_o(sa_set)
    );

    tlbsrch_full_part #(.ENTRIES(FA_ENTRIES)) u_fa (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i && !wr_to_sa),
        .wr_slot_i(wr_idx_i[SLOT_W-1:0]),
        .wr_tag_i(wr_tag), .wr_ps_i(wr_ps_i),
        .va_pair_i(lk_pair_i), .asid_i(lk_asid_i),
        .hit_o(fa_hit), .slot_o(fa_slot)
    );

    // Result register: a set-associative hit takes precedence over a fully associative one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_o <= 1'b0;
            idx_o <= '0;
        end else begin
            hit_o <= sa_hit || fa_hit;
            if (sa_hit)      idx_o <= IDX_W'({sa_way, sa_set});
            else if (fa_hit) idx_o <= IDX_W'(SA_TOTAL) + IDX_W'(fa_slot);
            else             idx_o <= '0;
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !hit_o);
    a_r6_sa_first: assert property (@(posedge clk) disable iff (!rst_n)
        sa_hit |=> (hit_o && (idx_o < IDX_W'(SA_TOTAL))));
    a_r7_fa_range: assert property (@(posedge clk) disable iff (!rst_n)
        (fa_hit && !sa_hit) |=> (hit_o && (idx_o >= IDX_W'(SA_TOTAL))));
    a_r9_miss_next: assert property (@(posedge clk) disable iff (!rst_n)
        (!sa_hit && !fa_hit) |=> !hit_o);
endmodule

// File: tb/tlbsrch_top_tb.sv
module tlbsrch_top_tb;
    localparam int W = 4, S = 16, F = 8;
    localparam int SAT = W * S;
    localparam int IW = $clog2(SAT + F);

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, wr_present = 1'b0, wr_global = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [9:0] wr_asid = '0, lk_asid = '0;
    logic [34:0] wr_pair = '0, lk_pair = '0;
    logic [5:0] wr_ps = 6'd12, sa_ps = 6'd12;
    logic hit;
    logic [IW-1:0] idx;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    tlbsrch_top #(.SA_WAYS(W), .SA_SETS(S), .FA_ENTRIES(F)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
        .wr_present_i(wr_present), .wr_global_i(wr_global), .wr_asid_i(wr_asid),
        .wr_pair_i(wr_pair), .wr_ps_i(wr_ps), .lk_pair_i(lk_pair),
        .lk_asid_i(lk_asid), .sa_ps_i(sa_ps), .hit_o(hit), .idx_o(idx));

    task automatic check(bit eh, int ei, string req);
        checks++;
        if (hit !== eh || (eh && idx !== IW'(ei))) begin
            errors++;
            $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d", req, hit, idx, eh, ei);
        end
    endtask

    task automatic put(int i, bit ex, bit gl, int asid, logic [34:0] pair, int ps);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(i); wr_present = ex; wr_global = gl;
        wr_asid = 10'(asid); wr_pair = pair; wr_ps = 6'(ps);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(logic [34:0] pair, int asid, int ps, bit eh, int ei, string req);
        @(negedge clk);
        lk_pair = pair; lk_asid = 10'(asid); sa_ps = 6'(ps);
        @(negedge clk);
        check(eh, ei, req);
    endtask

    function automatic logic [34:0] sweep_pair(int w, int s);
        return 35'(((w * 7 + 3) << 4) | s);
    endfunction

    initial begin
        #(20 * 20000);
        errors++; checks++;
        $display("FAIL watchdog: hit=%0b idx=%0d expected completion", hit, idx);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: nothing hits after reset
        for (int v = 0; v < 4; v++) look(35'(v * 1234567), 0, 12, 1'b0, 0, "R1");
        // R10 R2: fill way s%W of every set, then look each one up with 4 KiB pages
        for (int s = 0; s < S; s++)
            put((s % W) * S + s, 1'b1, 1'b0, s % 8, sweep_pair(s % W, s), 12);
        for (int s = 0; s < S; s++)
            look(sweep_pair(s % W, s), s % 8, 12, 1'b1, (s % W) * S + s, "R2_R10");
        // R4: wrong identifier misses, global entry hits under any identifier
        look(sweep_pair(1, 5), 6, 12, 1'b0, 0, "R4");
        look(sweep_pair(2, 6), 7, 12, 1'b0, 0, "R4");
        put(3 * S + 5, 1'b1, 1'b1, 0, 35'h7_0005, 12);
        look(35'h7_0005, 3, 12, 1'b1, 3 * S + 5, "R4");
        look(35'h7_0005, 1000, 12, 1'b1, 3 * S + 5, "R4");
        // R3: cleared present bit never matches even with matching fields
        put(2 * S + 2, 1'b0, 1'b1, 2, sweep_pair(2, 2), 12);
        look(sweep_pair(2, 2), 2, 12, 1'b0, 0, "R3");
        // R5 R8: page size 14, low two pair bits ignored, two ways match in set 9
        put(3 * S + 9, 1'b1, 1'b0, 4, 35'((100 << 6) | (9 << 2) | 1), 12);
        put(2 * S + 9, 1'b1, 1'b0, 4, 35'((100 << 6) | (9 << 2) | 2), 12);
        look(35'((100 << 6) | (9 << 2) | 3), 4, 14, 1'b1, 2 * S + 9, "R5_R8");
        look(35'((100 << 6) | (9 << 2) | 0), 4, 14, 1'b1, 2 * S + 9, "R5_R8");
        look(35'((100 << 6) | (9 << 2) | 3), 4, 12, 1'b0, 0, "R5");
        // R7: full entry 3 with 2 MiB pages ignores the set-part page size
        put(SAT + 3, 1'b1, 1'b0, 9, 35'(55 << 9), 21);
        look(35'((55 << 9) | 9'h1AB), 9, 12, 1'b1, SAT + 3, "R7");
        look(35'((55 << 9) | 9'h1AB), 9, 14, 1'b1, SAT + 3, "R7");
        look(35'((54 << 9) | 9'h1AB), 9, 12, 1'b0, 0, "R7");
        // R8: entry 1 with 8 KiB pages also matches, lower index wins
        put(SAT + 1, 1'b1, 1'b0, 9, 35'((55 << 9) | 9'h1AA), 13);
        look(35'((55 << 9) | 9'h1AB), 9, 12, 1'b1, SAT + 1, "R8");
        look(35'((55 << 9) | 9'h1AC), 9, 12, 1'b1, SAT + 3, "R7_R8");
        // R6: set-associative way 0 of set 11 takes precedence
        put(0 * S + 11, 1'b1, 1'b0, 9, 35'((55 << 9) | 9'h1AB), 12);
        look(35'((55 << 9) | 9'h1AB), 9, 12, 1'b1, 11, "R6");
        // R9: output follows the inputs only after the next rising edge
        look(35'h1_2345, 0, 12, 1'b0, 0, "R9");
        @(negedge clk);
        lk_pair = sweep_pair(0, 4); lk_asid = 10'd4; sa_ps = 6'd12;
        #1 check(1'b0, 0, "R9");
        @(negedge clk);
        check(1'b1, 4, "R9");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule